// File: doc/BRIEF.md
# Character LCD Bus Cycle Engine

This block runs one transfer at a time on the parallel bus of a character LCD controller. The bus has a register select line, a read/write line, an enable strobe and an 8-bit data bus. A request carries a register-select bit, a read flag and a byte. The engine then sequences the bus cycle. It holds the select and direction lines for a setup window, raises the enable for a fixed high width, and lowers it for a hold and recovery window. On reads it samples the bus during the last cycle of the enable-high phase. The data bus is driven only on writes, through a separate output enable.

Every controller instruction takes time to execute, so each transfer is followed by a hold-off before the next request can enter. The `poll_mode` pin picks how that hold-off ends. With `poll_mode` low, the engine waits a fixed time chosen from the command itself: a long wait for clear and home, a spacing wait for character-generator RAM accesses, and a short wait for the rest. With `poll_mode` high, the engine issues status reads until the busy bit clears. All cycle counts are parameters, derived from the clock frequency and the times in nanoseconds.

Requests enter over a valid/ready handshake. `req_ready` is high only when the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. Read results have no back-pressure: each appears as a single-cycle `rd_valid` pulse.

Top module: `lcd_bus_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_ready` is 1, and `lcd_e`, `lcd_d_oe` and `rd_valid` are 0.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` is low from the next cycle for exactly TB+W cycles. TB = S+H+L is the bus cycle length and W is the hold-off defined in R6 to R10.
- R3: Before each enable rise, `lcd_rs`, `lcd_rw`, `lcd_d_oe` and `lcd_d_out` are stable for at least S cycles. `lcd_e` is high for exactly H cycles. It stays low for L = max(hold, cycle - S - H) cycles with these lines unchanged.
- R4: On a write (`lcd_rw`=0), `lcd_d_oe` is 1 and `lcd_d_out` carries the request byte throughout the enable pulse. On a read (`lcd_rw`=1), `lcd_d_oe` is 0.
- R5: A requested read returns the byte seen on `lcd_d_in` during the last enable-high cycle. It is returned as a single-cycle `rd_valid` pulse with `rd_data` at the end of the bus cycle, in request order. Status polls produce no `rd_valid`.
- R6: In fixed mode, a command write (rs=0) of 0x01 (clear) or 0x02/0x03 (home) is followed by the long wait.
- R7: In fixed mode, other command writes, and rs=1 accesses while display-RAM addressing is selected, are followed by the short command wait.
- R8: A command write with bits [7:6]=01 selects character-generator addressing. A command write with bit 7=1, or a clear or home, selects display-RAM addressing. While character-generator addressing is selected, each rs=1 access is followed by the CG spacing wait, in both modes.
- R9: A status read (rs=0, read) completes with no hold-off and no polling, in both modes.
- R10: In poll mode, every other transfer (after any CG spacing wait) is followed by back-to-back status reads with rs=0 and rw=1. These continue until bit 7 of the returned byte is 0, and the last read is the first one with bit 7 clear. No fixed command wait applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_mode | input | 1 | Completion method, sampled at acceptance: 1 = poll busy bit, 0 = fixed wait |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_rs | input | 1 | Register select for the transfer |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_data | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 8 | Returned read byte |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus direction, 1 = read |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_d_out | output | 8 | Data driven onto the bus |
| lcd_d_oe | output | 1 | Data bus output enable |
| lcd_d_in | input | 8 | Data read from the bus |

## Verification
A wrong addressing-mode flag or wrong command decode changes no bus waveform. It shows only in how long `req_ready` stays low after the transfer. The bench therefore measures that interval for every request, so a fault shows up within one hold-off of the transfer that triggered it. A phase-counter fault shows up on the very next enable pulse, as a wrong high width or a short setup. A fault in the poll loop shows up as a wrong count of status reads before `req_ready` returns. A fault in the read path shows up on the next `rd_valid`, as a wrong byte or a missing pulse.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  localparam int BUS_W = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD} bus_phase_e;
  typedef enum logic [1:0] {EN_IDLE, EN_XFER, EN_GAP, EN_POLL} eng_state_e;
  typedef enum logic [1:0] {GAP_NONE, GAP_LONG, GAP_CMD, GAP_CG} gap_class_e;

  function automatic int ns_to_cycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/lcd_cycle_seq.sv
module lcd_cycle_seq
  import lcd_bus_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int HIGH_CYC  = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rs,
  input  logic             start_rnw,
  input  logic [BUS_W-1:0] start_data,
  output logic             done,
  output logic [BUS_W-1:0] rdata,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e,
  output logic [BUS_W-1:0] lcd_d_out,
  output logic             lcd_d_oe,
  input  logic [BUS_W-1:0] lcd_d_in
);

  localparam int MAX_A = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  bus_phase_e       phase;
  logic [CW-1:0]    cnt;
  logic             rs_q, rnw_q, e_q, oe_q;
  logic [BUS_W-1:0] data_q;
  logic             last;

  assign last = (cnt == '0);
  assign done = (phase == PH_HOLD) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      rs_q   <= 1'b0;
      rnw_q  <= 1'b1;
      e_q    <= 1'b0;
      oe_q   <= 1'b0;
      data_q <= '0;
      rdata  <= '0;
    end else if (start) begin
      phase  <= PH_SETUP;
      cnt    <= CW'(SETUP_CYC - 1);
      rs_q   <= start_rs;
      rnw_q  <= start_rnw;
      data_q <= start_data;
      oe_q   <= !start_rnw;
      e_q    <= 1'b0;
    end else begin
      case (phase)
        PH_SETUP: begin
          if (last) begin
            phase <= PH_HIGH;
            cnt   <= CW'(HIGH_CYC - 1);
            e_q   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (last) begin
            phase <= PH_HOLD;
            cnt   <= CW'(HOLD_CYC - 1);
            e_q   <= 1'b0;
            rdata <= lcd_d_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (last) begin
            phase <= PH_IDLE;
            oe_q  <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign lcd_rs    = rs_q;
  assign lcd_rw    = rnw_q;
  assign lcd_e     = e_q;
  assign lcd_d_out = data_q;
  assign lcd_d_oe  = oe_q;

  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_d_oe |-> !lcd_rw);

  // R3
  e_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)));

  // R3
  e_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |=> !lcd_e);

endmodule

// File: rtl/lcd_wait_class.sv
module lcd_wait_class
  import lcd_bus_pkg::*;
(
  input  logic             rs,
  input  logic             rnw,
  input  logic [BUS_W-1:0] data,
  input  logic             cg_sel,
  input  logic             poll,
  output gap_class_e       cls,
  output logic             cg_next
);

  logic cmd_wr, is_clear, is_home;

  assign cmd_wr   = !rs && !rnw;
  assign is_clear = (data == 8'h01);
  assign is_home  = (data[7:1] == 7'h01);

  always_comb begin
    cg_next = cg_sel;
    if (cmd_wr) begin
      if (data[7])                  cg_next = 1'b0;
      else if (data[6])             cg_next = 1'b1;
      else if (is_clear || is_home) cg_next = 1'b0;
    end
  end

  always_comb begin
    if (rs)        cls = cg_sel ? GAP_CG : (poll ? GAP_NONE : GAP_CMD);
    else if (rnw)  cls = GAP_NONE;
    else if (poll) cls = GAP_NONE;
    else           cls = (is_clear || is_home) ? GAP_LONG : GAP_CMD;
  end

endmodule

// File: rtl/lcd_gap_timer.sv
module lcd_gap_timer
  import lcd_bus_pkg::*;
#(
  parameter int LONG_CYC = 1,
  parameter int CMD_CYC  = 1,
  parameter int CG_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  gap_class_e cls,
  output logic       last
);

  localparam int MAX_A = (LONG_CYC > CMD_CYC) ? LONG_CYC : CMD_CYC;
  localparam int MAX_C = (MAX_A > CG_CYC) ? MAX_A : CG_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      case (cls)
        GAP_LONG: cnt <= CW'(LONG_CYC);
        GAP_CMD:  cnt <= CW'(CMD_CYC);
        GAP_CG:   cnt <= CW'(CG_CYC);
        default:  cnt <= '0;
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CW'(1));

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int T_SETUP_NS = 60,
  parameter int T_EHIGH_NS = 450,
  parameter int T_HOLD_NS  = 20,
  parameter int T_CYCLE_NS = 1000,
  parameter int T_LONG_NS  = 1640000,
  parameter int T_CMD_NS   = 40000,
  parameter int T_CG_NS    = 120000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rs,
  input  logic             req_rnw,
  input  logic [BUS_W-1:0] req_data,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_data,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e,
  output logic [BUS_W-1:0] lcd_d_out,
  output logic             lcd_d_oe,
  input  logic [BUS_W-1:0] lcd_d_in
);

  localparam int SETUP_C = ns_to_cycles(T_SETUP_NS, CLK_MHZ);
  localparam int HIGH_C  = ns_to_cycles(T_EHIGH_NS, CLK_MHZ);
  localparam int HMIN_C  = ns_to_cycles(T_HOLD_NS, CLK_MHZ);
  localparam int CYC_C   = ns_to_cycles(T_CYCLE_NS, CLK_MHZ);
  localparam int REST_C  = CYC_C - SETUP_C - HIGH_C;
  localparam int HOLD_C  = (REST_C > HMIN_C) ? REST_C : HMIN_C;
  localparam int LONG_C  = ns_to_cycles(T_LONG_NS, CLK_MHZ);
  localparam int CMD_C   = ns_to_cycles(T_CMD_NS, CLK_MHZ);
  localparam int CG_C    = ns_to_cycles(T_CG_NS, CLK_MHZ);

  eng_state_e       state, state_nxt;
  logic             cur_rs, cur_rnw, mode_q, cg_q, cg_next;
  logic [BUS_W-1:0] cur_data;
  logic             fire, need_poll;
  logic             seq_start, poll_start, gap_load, gap_last;
  logic             sq_go, sq_rs, sq_rnw, seq_done;
  logic [BUS_W-1:0] sq_data, seq_rdata;
  gap_class_e       cls;
  logic             user_rd_done;

  assign req_ready = (state == EN_IDLE);
  assign fire      = req_valid && req_ready;
  assign need_poll = mode_q && !(!cur_rs && cur_rnw);

  lcd_wait_class u_class (
    .rs      (cur_rs),
    .rnw     (cur_rnw),
    .data    (cur_data),
    .cg_sel  (cg_q),
    .poll    (mode_q),
    .cls     (cls),
    .cg_next (cg_next)
  );

  always_comb begin
    state_nxt  = state;
    seq_start  = 1'b0;
    poll_start = 1'b0;
    gap_load   = 1'b0;
    case (state)
      EN_IDLE: begin
        if (fire) begin
          seq_start = 1'b1;
          state_nxt = EN_XFER;
        end
      end
      EN_XFER: begin
        if (seq_done) begin
          if (cls != GAP_NONE) begin
            gap_load  = 1'b1;
            state_nxt = EN_GAP;
          end else if (need_poll) begin
            poll_start = 1'b1;
            state_nxt  = EN_POLL;
          end else begin
            state_nxt = EN_IDLE;
          end
        end
      end
      EN_GAP: begin
        if (gap_last) begin
          if (need_poll) begin
            poll_start = 1'b1;
            state_nxt  = EN_POLL;
          end else begin
            state_nxt = EN_IDLE;
          end
        end
      end
      EN_POLL: begin
        if (seq_done) begin
          if (seq_rdata[BUS_W-1]) poll_start = 1'b1;
          else                    state_nxt  = EN_IDLE;
        end
      end
      default: state_nxt = EN_IDLE;
    endcase
  end

  assign sq_go   = seq_start || poll_start;
  assign sq_rs   = seq_start ? req_rs   : 1'b0;
  assign sq_rnw  = seq_start ? req_rnw  : 1'b1;
  assign sq_data = seq_start ? req_data : '0;

  assign user_rd_done = (state == EN_XFER) && seq_done && cur_rnw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= EN_IDLE;
      cur_rs   <= 1'b0;
      cur_rnw  <= 1'b0;
      cur_data <= '0;
      mode_q   <= 1'b0;
      cg_q     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state    <= state_nxt;
      rd_valid <= user_rd_done;
      if (fire) begin
        cur_rs   <= req_rs;
        cur_rnw  <= req_rnw;
        cur_data <= req_data;
        mode_q   <= poll_mode;
      end
      if ((state == EN_XFER) && seq_done) cg_q <= cg_next;
      if (user_rd_done) rd_data <= seq_rdata;
    end
  end

  lcd_cycle_seq #(
    .SETUP_CYC (SETUP_C),
    .HIGH_CYC  (HIGH_C),
    .HOLD_CYC  (HOLD_C)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sq_go),
    .start_rs   (sq_rs),
    .start_rnw  (sq_rnw),
    .start_data (sq_data),
    .done       (seq_done),
    .rdata      (seq_rdata),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_d_out  (lcd_d_out),
    .lcd_d_oe   (lcd_d_oe),
    .lcd_d_in   (lcd_d_in)
  );

  lcd_gap_timer #(
    .LONG_CYC (LONG_C),
    .CMD_CYC  (CMD_C),
    .CG_CYC   (CG_C)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (gap_load),
    .cls   (cls),
    .last  (gap_last)
  );

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R2
  e_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> !req_ready);

  // R10
  poll_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == EN_POLL && lcd_e) |-> (!lcd_rs && lcd_rw && !lcd_d_oe));

endmodule

// File: tb/sim_lcd_bus_engine.sv
module sim_lcd_bus_engine;

  localparam int AS = 15;
  localparam int PW = 113;
  localparam int HL = 122;
  localparam int TB = AS + PW + HL;
  localparam int WL = 2000;
  localparam int WC = 400;
  localparam int WG = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       poll_mode = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rs = 1'b0;
  logic       req_rnw = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_d_oe;
  logic [7:0] lcd_d_out, lcd_d_in;

  int checks = 0;
  int errors = 0;
  int busy_left = 0;
  int stat_reads = 0;
  logic [7:0] rd_pat = 8'h5A;
  logic [7:0] cur_wdata = 8'h00;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  assign lcd_d_in = (!lcd_rs && lcd_rw) ? {busy_left != 0, 7'h25} : rd_pat;

  always @(negedge lcd_e) begin
    if (!lcd_rs && lcd_rw) begin
      stat_reads++;
      if (busy_left > 0) busy_left--;
    end
  end

  lcd_bus_engine #(
    .T_LONG_NS (8000),
    .T_CMD_NS  (1600),
    .T_CG_NS   (4000)
  ) u0 (
    .clk, .rst_n, .poll_mode, .req_valid, .req_ready, .req_rs, .req_rnw,
    .req_data, .rd_valid, .rd_data, .lcd_rs, .lcd_rw, .lcd_e, .lcd_d_out,
    .lcd_d_oe, .lcd_d_in
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: bus timing, direction and the read scoreboard
  logic [10:0] prev_tuple = '0;
  logic        prev_e = 1'b0;
  int          stable_cnt = 0;
  int          high_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [10:0] tup;
      tup = {lcd_rs, lcd_rw, lcd_d_oe, lcd_d_out};
      if (tup == prev_tuple) stable_cnt++;
      else stable_cnt = 1;
      prev_tuple = tup;
      if (lcd_e && !prev_e) begin
        chk(stable_cnt >= AS + 1, "R3", "setup before E rise", stable_cnt - 1, AS);
        chk(lcd_d_oe == !lcd_rw, "R4", "output enable vs direction", lcd_d_oe, !lcd_rw);
        if (!lcd_rw) chk(lcd_d_out == cur_wdata, "R4", "write data on bus", lcd_d_out, cur_wdata);
      end
      if (lcd_e) high_cnt++;
      if (!lcd_e && prev_e) begin
        chk(high_cnt == PW, "R3", "E high width", high_cnt, PW);
        high_cnt = 0;
      end
      prev_e = lcd_e;
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected rd_valid", rd_data, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R5", "read data", rd_data, e);
        end
      end
    end
  end

  task automatic xfer(input bit rs, input bit rnw, input logic [7:0] d, input int busy,
                      input logic [7:0] exp_rd, input int exp_low, input int exp_polls,
                      input string req);
    int low;
    int user_stat;
    @(negedge clk);
    busy_left = busy;
    stat_reads = 0;
    cur_wdata = d;
    req_rs = rs;
    req_rnw = rnw;
    req_data = d;
    req_valid = 1'b1;
    if (rnw) exp_q.push_back(exp_rd);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    low = 0;
    while (!req_ready) begin
      low++;
      @(negedge clk);
    end
    chk(low == exp_low, req, "ready-low cycles", low, exp_low);
    user_stat = (!rs && rnw) ? 1 : 0;
    chk(stat_reads - user_stat == exp_polls, req, "status polls", stat_reads - user_stat, exp_polls);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready && !lcd_e && !lcd_d_oe && !rd_valid, "R1", "outputs in reset",
        {req_ready, lcd_e, lcd_d_oe, rd_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !lcd_e && !lcd_d_oe && !rd_valid, "R1", "outputs after reset",
        {req_ready, lcd_e, lcd_d_oe, rd_valid}, 4'b1000);

    // fixed-delay mode
    poll_mode = 1'b0;
    xfer(0, 0, 8'h38, 0, 8'h00, TB + WC, 0, "R7");
    xfer(0, 0, 8'h01, 0, 8'h00, TB + WL, 0, "R6");
    xfer(0, 0, 8'h02, 0, 8'h00, TB + WL, 0, "R6");
    xfer(1, 0, 8'h41, 0, 8'h00, TB + WC, 0, "R7");
    xfer(1, 1, 8'h00, 0, 8'h5A, TB + WC, 0, "R5");
    xfer(0, 1, 8'h00, 0, 8'h25, TB, 0, "R9");
    xfer(0, 0, 8'h58, 0, 8'h00, TB + WC, 0, "R8");
    xfer(1, 0, 8'h1F, 0, 8'h00, TB + WG, 0, "R8");
    xfer(1, 1, 8'h00, 0, 8'h5A, TB + WG, 0, "R8");
    xfer(0, 0, 8'h80, 0, 8'h00, TB + WC, 0, "R8");
    xfer(1, 0, 8'h33, 0, 8'h00, TB + WC, 0, "R8");

    // busy-poll mode
    poll_mode = 1'b1;
    xfer(0, 0, 8'h0C, 3, 8'h00, TB * 5, 4, "R10");
    xfer(1, 0, 8'h44, 0, 8'h00, TB * 2, 1, "R10");
    xfer(0, 0, 8'h40, 1, 8'h00, TB * 3, 2, "R10");
    xfer(1, 0, 8'h0E, 2, 8'h00, TB + WG + TB * 3, 3, "R8");
    xfer(0, 0, 8'h01, 0, 8'h00, TB * 2, 1, "R10");
    xfer(1, 1, 8'h00, 1, 8'h5A, TB * 3, 2, "R5");
    xfer(0, 1, 8'h00, 2, 8'hA5, TB, 0, "R9");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "reads left unreturned", exp_q.size(), 0);
    finish_run();
  end

endmodule